// File: doc/BRIEF.md
# Channel Scan Sequencer with Gain Memory

This block steps an analog input multiplexer through a band of channels, moving one step for each finished conversion. A single register write sets the band as a first channel and a last channel. The current channel starts at the first channel, and after the last channel it wraps back to the first. The band may also wrap through channel `N_CH-1` to channel 0. The current channel number is driven to the multiplexer.

A memory holds one gain/range code for each channel. Software loads it one channel at a time. It first writes a band whose first and last channel are the same, then writes the range register. The stored code is written into the slot of the current channel. The code of the current channel is driven to the amplifier all the time. The top bit of a code marks a differential pair: from such a channel the scan moves two channels forward, not one.

Every converter result is returned as a 16-bit word. The channel it was taken from sits in the top four bits and the 12-bit data sits below it, so a reader can detect lost samples.

Top module: `mux_scan_seq`

## Requirements
- R1: After reset the current channel is 0, the first and last channels are 0, every stored range code is 0, `sample_valid` is 0 and `sample_out` is 0.
- R2: A write to byte address 0x04 takes the first channel from `wr_data[7:0]` and the last channel from `wr_data[15:8]`, each reduced modulo `N_CH`. From the next cycle, `chan_out` shows the first channel.
- R3: A write to byte address 0x02 stores `wr_data[5:0]` as the range code of the current channel. `range_out` always shows the stored code of the current channel.
- R4: A `conv_done` pulse on a channel whose code has bit 5 clear moves `chan_out` to the next channel. When the current channel equals the last channel, it moves back to the first channel.
- R5: When the first channel is above the last channel, the scan runs up to channel `N_CH-1`, continues at channel 0 and goes on to the last channel.
- R6: When first equals last, `conv_done` leaves `chan_out` on that channel.
- R7: One cycle after `conv_done`, `sample_valid` is high for exactly one cycle. At that point `sample_out` holds the channel that was current at the conversion in bits 15:12 and `adc_data` in bits 11:0. With no `conv_done`, `sample_valid` stays low.
- R8: When the current channel's code has bit 5 set (differential), `conv_done` moves forward two channels modulo `N_CH`. It moves back to the first channel instead when the current channel, or the channel after it, is the last channel.
- R9: Writes to any byte address other than 0x04 and 0x02 change neither `chan_out` nor any stored range code.
- R10: When a band write and `conv_done` fall in the same cycle, the band write decides the next channel, and the sample is tagged with the channel that was current before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 16 | Write data |
| conv_done | input | 1 | One-cycle pulse marking a finished conversion |
| adc_data | input | 12 | Converter result, valid with `conv_done` |
| chan_out | output | 4 | Current multiplexer channel |
| range_out | output | 6 | Stored range code of the current channel |
| sample_valid | output | 1 | Tagged sample strobe |
| sample_out | output | 16 | Channel-tagged sample word |

## Verification
The bench goes after the wrap from last back to first. A design that compares against the wrong bound would walk out of the band or stop one channel short. It also runs a band that crosses channel 15 to channel 0, where a design that treats first-greater-than-last as empty would stall. Differential pairs are checked near the end of the band, where a design that skips this check jumps past the last channel instead of returning to the first. The bench also targets a band write that lands in the same cycle as a conversion: a design that gives the conversion priority would leave the channel on a stale value, and one that tags after the update would label the sample with the new channel.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Reduce a written channel byte into the channel range.
  function automatic int unsigned fold_chan(int unsigned raw, int unsigned n);
    return raw % n;
  endfunction

  // Channel that follows cur inside the band [first..last], modulo n.
  function automatic int unsigned next_chan(int unsigned cur, int unsigned first,
                                            int unsigned last, bit pair,
                                            int unsigned n);
    int unsigned one_up;
    one_up = (cur + 1) % n;
    if (cur == last || (pair && one_up == last)) return first;
    if (pair) return (cur + 2) % n;
    return one_up;
  endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode #(
  parameter int ADDR_W    = 5,
  parameter int MUX_OFS   = 4,
  parameter int RANGE_OFS = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mux_wr,
  output logic              range_wr
);
  always_comb begin
    mux_wr   = wr_en && (wr_addr == ADDR_W'(MUX_OFS));
    range_wr = wr_en && (wr_addr == ADDR_W'(RANGE_OFS));
  end
endmodule

// File: rtl/seq_pointer.sv
module seq_pointer
  import seq_pkg::*;
#(
  parameter int N_CH = 16,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mux_wr,
  input  logic [7:0]      band_lo,
  input  logic [7:0]      band_hi,
  input  logic            step,
  input  logic            pair,
  output logic [CH_W-1:0] cur_q,
  output logic [CH_W-1:0] first_q,
  output logic [CH_W-1:0] last_q
);
  logic [CH_W-1:0] lo_fold, hi_fold, stepped;

  always_comb begin
    lo_fold = CH_W'(fold_chan(int'(band_lo), N_CH));
    hi_fold = CH_W'(fold_chan(int'(band_hi), N_CH));
    stepped = CH_W'(next_chan(int'(cur_q), int'(first_q), int'(last_q), pair, N_CH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (mux_wr) begin
      cur_q   <= lo_fold;
      first_q <= lo_fold;
      last_q  <= hi_fold;
    end else if (step) begin
      cur_q   <= stepped;
    end
  end
endmodule

// File: rtl/seq_gain_mem.sv
module seq_gain_mem #(
  parameter int N_CH    = 16,
  parameter int RANGE_W = 6,
  localparam int CH_W   = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CH_W-1:0]    sel,
  input  logic [RANGE_W-1:0] wcode,
  output logic [RANGE_W-1:0] rcode
);
  logic [RANGE_W-1:0] slot [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                              slot[g] <= '0;
      else if (we && sel == CH_W'(g))          slot[g] <= wcode;
    end
  end

  assign rcode = slot[sel];
endmodule

// File: rtl/seq_tagger.sv
module seq_tagger #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 12,
  localparam int SW    = CH_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CH_W-1:0]   chan,
  input  logic [DATA_W-1:0] data,
  output logic              valid,
  output logic [SW-1:0]     word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else begin
      valid <= take;
      if (take) word <= {chan, data};
    end
  end
endmodule

// File: rtl/mux_scan_seq.sv
module mux_scan_seq #(
  parameter int N_CH      = 16,
  parameter int DATA_W    = 12,
  parameter int RANGE_W   = 6,
  parameter int ADDR_W    = 5,
  parameter int MUX_OFS   = 4,
  parameter int RANGE_OFS = 2,
  localparam int CH_W     = $clog2(N_CH),
  localparam int SAMPLE_W = CH_W + DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [15:0]         wr_data,
  input  logic                conv_done,
  input  logic [DATA_W-1:0]   adc_data,
  output logic [CH_W-1:0]     chan_out,
  output logic [RANGE_W-1:0]  range_out,
  output logic                sample_valid,
  output logic [SAMPLE_W-1:0] sample_out
);
  // Named internal events, also observed by the bound checker.
  logic            mux_wr, range_wr, step_evt, pair_step;
  logic [CH_W-1:0] first_q, last_q;

  assign step_evt  = conv_done;
  assign pair_step = range_out[RANGE_W-1];

  seq_decode #(.ADDR_W(ADDR_W), .MUX_OFS(MUX_OFS), .RANGE_OFS(RANGE_OFS)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .mux_wr(mux_wr), .range_wr(range_wr)
  );

  seq_pointer #(.N_CH(N_CH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .mux_wr(mux_wr),
    .band_lo(wr_data[7:0]), .band_hi(wr_data[15:8]),
    .step(step_evt), .pair(pair_step),
    .cur_q(chan_out), .first_q(first_q), .last_q(last_q)
  );

  seq_gain_mem #(.N_CH(N_CH), .RANGE_W(RANGE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(range_wr), .sel(chan_out),
    .wcode(wr_data[RANGE_W-1:0]), .rcode(range_out)
  );

  seq_tagger #(.CH_W(CH_W), .DATA_W(DATA_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .take(step_evt), .chan(chan_out),
    .data(adc_data), .valid(sample_valid), .word(sample_out)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int N_CH    = 16,
  parameter int CH_W    = 4,
  parameter int DATA_W  = 12,
  parameter int RANGE_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mux_wr,
  input logic                     range_wr,
  input logic                     step_evt,
  input logic [15:0]              wr_data,
  input logic [DATA_W-1:0]        adc_data,
  input logic [CH_W-1:0]          chan,
  input logic [CH_W-1:0]          first_q,
  input logic [CH_W-1:0]          last_q,
  input logic [RANGE_W-1:0]       range_code,
  input logic                     sample_valid,
  input logic [CH_W+DATA_W-1:0]   sample_word
);
  p_mux_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mux_wr |=> int'(chan) == int'($past(wr_data[7:0])) % N_CH);

  p_mux_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mux_wr |=> int'(last_q) == int'($past(wr_data[15:8])) % N_CH);

  p_range_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    range_wr && !step_evt |=> range_code == $past(wr_data[RANGE_W-1:0]));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && !mux_wr && chan == last_q |=> chan == $past(first_q));

  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && !mux_wr && first_q == last_q |=> $stable(chan));

  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> sample_valid);

  p_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> !sample_valid);

  p_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> sample_word == {$past(chan), $past(adc_data)});

  p_hold_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_wr && !step_evt |=> $stable(chan));

  p_hold_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_wr && !range_wr && !step_evt |=> $stable(range_code));
endmodule

bind mux_scan_seq seq_chk #(
  .N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W), .RANGE_W(RANGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_wr(mux_wr), .range_wr(range_wr),
  .step_evt(step_evt), .wr_data(wr_data), .adc_data(adc_data),
  .chan(chan_out), .first_q(first_q), .last_q(last_q),
  .range_code(range_out), .sample_valid(sample_valid), .sample_word(sample_out)
);

// File: tb/sim_mux_scan_seq.sv
module sim_mux_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        conv_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [3:0]  chan_out;
  logic [5:0]  range_out;
  logic        sample_valid;
  logic [15:0] sample_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mux_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_done(conv_done), .adc_data(adc_data), .chan_out(chan_out),
    .range_out(range_out), .sample_valid(sample_valid), .sample_out(sample_out)
  );

  // Row: {kind[1:0], addr[4:0], data[15:0], exp_chan[3:0], exp_range[5:0], req[3:0]}
  localparam logic [1:0] K_WR = 2'd0, K_CV = 2'd1;

  function automatic logic [36:0] wr_row(logic [4:0] a, logic [15:0] d,
                                         logic [3:0] c, logic [5:0] r, logic [3:0] q);
    return {K_WR, a, d, c, r, q};
  endfunction
  function automatic logic [36:0] cv_row(logic [15:0] d, logic [3:0] c,
                                         logic [5:0] r, logic [3:0] q);
    return {K_CV, 5'd0, d, c, r, q};
  endfunction

  localparam int NV = 34;
  localparam logic [36:0] VEC [NV] = '{
    wr_row(5'h04, 16'h0303, 4'd3, 6'h00, 4'd2),   // R2 single band on 3
    wr_row(5'h02, 16'h0005, 4'd3, 6'h05, 4'd3),   // R3
    wr_row(5'h04, 16'h0505, 4'd5, 6'h00, 4'd2),
    wr_row(5'h02, 16'h0011, 4'd5, 6'h11, 4'd3),
    wr_row(5'h04, 16'h0404, 4'd4, 6'h00, 4'd2),
    wr_row(5'h02, 16'h0013, 4'd4, 6'h13, 4'd3),
    wr_row(5'h04, 16'h0503, 4'd3, 6'h05, 4'd2),   // band 3..5
    cv_row(16'h0abc, 4'd4, 6'h13, 4'd4),          // R4
    cv_row(16'h0123, 4'd5, 6'h11, 4'd4),
    cv_row(16'h0fff, 4'd3, 6'h05, 4'd4),          // R4 wrap last->first
    wr_row(5'h06, 16'h0000, 4'd3, 6'h05, 4'd9),   // R9 foreign address
    wr_row(5'h04, 16'h010e, 4'd14, 6'h00, 4'd2),  // band 14..1
    cv_row(16'h0001, 4'd15, 6'h00, 4'd5),         // R5
    cv_row(16'h0002, 4'd0, 6'h00, 4'd5),          // R5 through 15 -> 0
    cv_row(16'h0003, 4'd1, 6'h00, 4'd5),
    cv_row(16'h0004, 4'd14, 6'h00, 4'd5),
    wr_row(5'h04, 16'h0707, 4'd7, 6'h00, 4'd2),
    cv_row(16'h0005, 4'd7, 6'h00, 4'd6),          // R6 single channel
    wr_row(5'h04, 16'h0202, 4'd2, 6'h00, 4'd2),
    wr_row(5'h02, 16'h0021, 4'd2, 6'h21, 4'd3),   // differential code on 2
    wr_row(5'h04, 16'h0500, 4'd0, 6'h00, 4'd2),   // band 0..5
    cv_row(16'h0006, 4'd1, 6'h00, 4'd4),
    cv_row(16'h0007, 4'd2, 6'h21, 4'd4),
    cv_row(16'h0008, 4'd4, 6'h13, 4'd8),          // R8 pair step 2 -> 4
    cv_row(16'h0009, 4'd5, 6'h11, 4'd4),
    cv_row(16'h000a, 4'd0, 6'h00, 4'd4),
    wr_row(5'h04, 16'h0300, 4'd0, 6'h00, 4'd2),   // band 0..3
    cv_row(16'h000b, 4'd1, 6'h00, 4'd4),
    cv_row(16'h000c, 4'd2, 6'h21, 4'd4),
    cv_row(16'h000d, 4'd0, 6'h00, 4'd8),          // R8 pair reaching last -> first
    wr_row(5'h00, 16'h0015, 4'd0, 6'h00, 4'd9),   // R9 foreign address
    wr_row(5'h02, 16'hffe7, 4'd0, 6'h27, 4'd3),   // R3 upper bits dropped
    wr_row(5'h04, 16'hf1f2, 4'd2, 6'h21, 4'd2),   // R2 bytes folded mod 16
    cv_row(16'h0010, 4'd4, 6'h13, 4'd8)           // R8
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_conv(logic [11:0] d);
    @(negedge clk);
    conv_done = 1'b1; adc_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "chan", 32'(chan_out), 32'd0);
    chk("R1", "valid", 32'(sample_valid), 32'd0);
    chk("R1", "sample", 32'(sample_out), 32'd0);
    for (int c = 0; c < 16; c++) begin
      do_write(5'h04, {4'h0, 4'(c), 4'h0, 4'(c)});
      chk("R1", "chan sel", 32'(chan_out), 32'(c));
      chk("R1", "code zero", 32'(range_out), 32'd0);
    end

    prev = chan_out;
    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      string rq;
      v  = VEC[i];
      rq = $sformatf("R%0d", v[3:0]);
      if (v[36:35] == K_WR) begin
        do_write(v[34:30], v[29:14]);
        chk(rq, "valid idle", 32'(sample_valid), 32'd0);   // R7 no pulse
      end else begin
        do_conv(v[25:14]);
        chk("R7", "valid", 32'(sample_valid), 32'd1);
        chk("R7", "sample", 32'(sample_out), 32'({prev, v[25:14]}));
      end
      chk(rq, $sformatf("row %0d chan", i), 32'(chan_out), 32'(v[13:10]));
      chk(rq, $sformatf("row %0d range", i), 32'(range_out), 32'(v[9:4]));
      prev = v[13:10];
      @(negedge clk);
      chk("R7", "valid one cycle", 32'(sample_valid), 32'd0);
    end

    // R10: band write and conversion together; now on channel 4
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'h04; wr_data = 16'h0909;
    conv_done = 1'b1; adc_data = 12'h055;
    @(negedge clk);
    wr_en = 1'b0; conv_done = 1'b0;
    chk("R10", "chan", 32'(chan_out), 32'd9);
    chk("R10", "sample tag", 32'(sample_out), 32'h4055);

    // R1: reset mid-run clears pointer and the code stored on channel 0
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "chan after rst", 32'(chan_out), 32'd0);
    chk("R1", "code after rst", 32'(range_out), 32'd0);
    chk("R1", "valid after rst", 32'(sample_valid), 32'd0);
    finish_run();
  end
endmodule